// File: doc/BRIEF.md
# Banked Per-Line Sprite Selector

This block decides, once per video scanline, which sprites the renderer has to draw. A strobe at the start of a line sets it going. It then reads a sprite attribute table through a read port, beginning at entry 0 of the selected half and moving upward one entry at a time. It checks each entry against the current line. Every enabled sprite that overlaps the line produces a render request, and that request waits on a valid/ready handshake with the downstream pixel fetcher.

The attribute table is split into two halves of 64 entries. One control bit picks the live half, so software can fill the other half while the live one is on screen. The bit is captured only at line start.

Rendering time is capped by a pixel budget rather than by elapsed cycles. The selector keeps a running sum of the widths of the sprites it has issued. When the next candidate would push that sum above 512 pixels, the selector drops it and ends the line. Because of this, the set of sprites drawn on a line depends only on the table contents and the line number. It does not depend on how long the handshake stalls.

Top module: `spr_line_select`

## Requirements
- R1: While reset is held and on the first cycle after it, `req_valid` and `scan_done` are low.
- R2: The bank bit is sampled when `line_start` is high, and all reads for that line use it as address bit 6 (`attr_addr = {bank, index}`). A change of `bank_sel` during a line has no effect until the next `line_start`.
- R3: Entries are examined from index 0 upward. Requests of one line carry strictly increasing `req_id`, and `req_x` is the entry's x field.
- R4: Attribute word layout: bit 0 enable, bits 10:1 x, bits 20:11 y, bits 22:21 width code, bits 24:23 height code. A sprite is selected only if it is enabled and 0 <= line - y < height. Disabled or non-overlapping entries produce no request.
- R5: Size codes 0, 1, 2 and 3 mean 8, 16, 32 and 64 pixels. `req_width` carries the decoded width.
- R6: The widths issued in one line never total more than 512. The first selected sprite that would exceed 512 is not issued, and no later entry of that line is issued, even one that would fit.
- R7: `scan_done` rises after index 63 has been handled or once the issued total equals exactly 512. It then stays high, with `req_valid` low, until the next `line_start`.
- R8: While `req_valid` is high and `req_ready` is low, the request stays valid with unchanged id, x and width. Each accepted handshake consumes exactly one request.
- R9: A `line_start` during a scan abandons it. The pixel count and index restart at zero, and the new line delivers its full request list.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_start | input | 1 | One-cycle strobe that begins a new line's scan |
| line_num | input | 10 | Line number, sampled with `line_start` |
| bank_sel | input | 1 | Active table half, sampled with `line_start` |
| attr_addr | output | 7 | Table read address {bank, index} |
| attr_data | input | 25 | Attribute word for `attr_addr`, same cycle |
| req_valid | output | 1 | Render request pending |
| req_ready | input | 1 | Downstream accepts the request |
| req_id | output | 6 | Index of the requested sprite within its bank |
| req_x | output | 10 | Horizontal position of the sprite |
| req_width | output | 7 | Sprite width in pixels |
| scan_done | output | 1 | Scan for this line finished |

## Verification
Seven table fills are used, and each one separates a different outcome:
- A full bank of narrow sprites ends exactly at the budget on the last index.
- Sixteen-pixel sprites exhaust the budget halfway through the bank.
- A sparse mix of widths and heights exercises the overlap test.
- Two halves with different contents expose wrong bank addressing or resampling of the bank bit during a line.
- A fill that runs just past the budget has a narrow sprite after the overflowing one, so a selector that keeps scanning would issue it.
- An empty fill checks the path that ends on index 63 alone.
- Lines placed one below, on, and one beyond each edge of a sprite's height pin down the overlap boundaries.

Runs with the ready line stalled on two cycles of every three confirm that the request list is the same as with ready held high.

// File: rtl/spr_scan_pkg.sv
package spr_scan_pkg;
    localparam int ENTRIES  = 64;
    localparam int BANKS    = 2;
    localparam int IDX_W    = $clog2(ENTRIES);
    localparam int ADDR_W   = IDX_W + $clog2(BANKS);
    localparam int COORD_W  = 10;
    localparam int BUDGET   = 512;
    localparam int CNT_W    = $clog2(BUDGET + 1);
    localparam int SIZE_W   = 7;
    localparam int MIN_SIZE = 8;

    typedef struct packed {
        logic [1:0]         hcode;
        logic [1:0]         wcode;
        logic [COORD_W-1:0] y;
        logic [COORD_W-1:0] x;
        logic               en;
    } spr_attr_t;

    localparam int ATTR_W = $bits(spr_attr_t);

    typedef struct packed {
        logic [IDX_W-1:0]   id;
        logic [COORD_W-1:0] x;
        logic [SIZE_W-1:0]  w;
    } spr_req_t;

    typedef enum logic [1:0] {S_IDLE, S_SCAN, S_EMIT, S_DONE} scan_state_t;

    function automatic logic [SIZE_W-1:0] code_to_px(input logic [1:0] c);
        return SIZE_W'(MIN_SIZE) << c;
    endfunction
endpackage

// File: rtl/spr_hit_test.sv
module spr_hit_test
    import spr_scan_pkg::*;
(
    input  spr_attr_t          attr,
    input  logic [COORD_W-1:0] line,
    output logic               hit,
    output logic [SIZE_W-1:0]  width
);
    logic [COORD_W:0]   delta;
    logic [SIZE_W-1:0]  height;

    always_comb begin
        delta  = {1'b0, line} - {1'b0, attr.y};
        height = code_to_px(attr.hcode);
        width  = code_to_px(attr.wcode);
        hit    = attr.en && !delta[COORD_W]
                 && (delta[COORD_W-1:0] < COORD_W'(height));
    end
endmodule

// File: rtl/spr_budget.sv
module spr_budget
    import spr_scan_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              take,
    input  logic [SIZE_W-1:0] cand_w,
    output logic              fits,
    output logic              full
);
    logic [CNT_W-1:0] used;
    logic [CNT_W:0]   sum;

    always_comb begin
        sum  = {1'b0, used} + (CNT_W+1)'(cand_w);
        fits = sum <= (CNT_W+1)'(BUDGET);
        full = used == CNT_W'(BUDGET);
    end

    always_ff @(posedge clk) begin
        if (rst || clr)  used <= '0;
        else if (take)   used <= sum[CNT_W-1:0];
    end
endmodule

// File: rtl/spr_line_select.sv
module spr_line_select
    import spr_scan_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               line_start,
    input  logic [COORD_W-1:0] line_num,
    input  logic               bank_sel,
    output logic [ADDR_W-1:0]  attr_addr,
    input  logic [ATTR_W-1:0]  attr_data,
    output logic               req_valid,
    input  logic               req_ready,
    output logic [IDX_W-1:0]   req_id,
    output logic [COORD_W-1:0] req_x,
    output logic [SIZE_W-1:0]  req_width,
    output logic               scan_done
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ENTRIES - 1);

    scan_state_t        state;
    logic [IDX_W-1:0]   idx;
    logic               bank_q;
    logic [COORD_W-1:0] line_q;
    spr_req_t           req_q;
    spr_attr_t          cur;
    logic               hit, fits, full, take;
    logic [SIZE_W-1:0]  cur_w;

    assign cur       = spr_attr_t'(attr_data);
    assign attr_addr = {bank_q, idx};

    spr_hit_test u_hit (
        .attr  (cur),
        .line  (line_q),
        .hit   (hit),
        .width (cur_w)
    );

    assign take = (state == S_SCAN) && hit && fits && !line_start;

    spr_budget u_budget (
        .clk    (clk),
        .rst    (rst),
        .clr    (line_start),
        .take   (take),
        .cand_w (cur_w),
        .fits   (fits),
        .full   (full)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= S_IDLE;
            idx    <= '0;
            bank_q <= 1'b0;
            line_q <= '0;
            req_q  <= '0;
        end else if (line_start) begin
            state  <= S_SCAN;
            idx    <= '0;
            bank_q <= bank_sel;
            line_q <= line_num;
        end else begin
            unique case (state)
                S_SCAN: begin
                    if (hit) begin
                        if (fits) begin
                            req_q <= '{id: idx, x: cur.x, w: cur_w};
                            state <= S_EMIT;
                        end else begin
                            state <= S_DONE;
                        end
                    end else if (idx == LAST_IDX) begin
                        state <= S_DONE;
                    end else begin
                        idx <= idx + 1'b1;
                    end
                end
                S_EMIT: begin
                    if (req_ready) begin
                        if (idx == LAST_IDX || full) begin
                            state <= S_DONE;
                        end else begin
                            idx   <= idx + 1'b1;
                            state <= S_SCAN;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    assign req_valid = (state == S_EMIT);
    assign scan_done = (state == S_DONE);
    assign req_id    = req_q.id;
    assign req_x     = req_q.x;
    assign req_width = req_q.w;
endmodule

// File: rtl/spr_line_select_chk.sv
module spr_line_select_chk
    import spr_scan_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               line_start,
    input logic [COORD_W-1:0] line_num,
    input logic               bank_sel,
    input logic [ADDR_W-1:0]  attr_addr,
    input logic [ATTR_W-1:0]  attr_data,
    input logic               req_valid,
    input logic               req_ready,
    input logic [IDX_W-1:0]   req_id,
    input logic [COORD_W-1:0] req_x,
    input logic [SIZE_W-1:0]  req_width,
    input logic               scan_done
);
    logic             bank_l;
    logic [CNT_W:0]   issued;
    logic             have_last;
    logic [IDX_W-1:0] last_id;

    always_ff @(posedge clk) begin
        if (rst) begin
            bank_l    <= 1'b0;
            issued    <= '0;
            have_last <= 1'b0;
            last_id   <= '0;
        end else if (line_start) begin
            bank_l    <= bank_sel;
            issued    <= '0;
            have_last <= 1'b0;
        end else if (req_valid && req_ready) begin
            issued    <= issued + (CNT_W+1)'(req_width);
            have_last <= 1'b1;
            last_id   <= req_id;
        end
    end

    a_r1_reset_idle: assert property (@(posedge clk)
        rst |=> (!req_valid && !scan_done));

    a_r2_bank_held: assert property (@(posedge clk) disable iff (rst)
        !line_start |-> attr_addr[ADDR_W-1] == bank_l);

    a_r3_ascending: assert property (@(posedge clk) disable iff (rst)
        (req_valid && have_last) |-> req_id > last_id);

    a_r6_budget_cap: assert property (@(posedge clk) disable iff (rst)
        issued <= (CNT_W+1)'(BUDGET));

    a_r7_done_quiet: assert property (@(posedge clk) disable iff (rst)
        scan_done |-> !req_valid);

    a_r7_done_holds: assert property (@(posedge clk) disable iff (rst)
        (scan_done && !line_start) |=> scan_done);

    a_r8_req_stable: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_ready && !line_start) |=>
            (req_valid && $stable(req_id) && $stable(req_x) && $stable(req_width)));
endmodule

bind spr_line_select spr_line_select_chk u_chk (.*);

// File: tb/spr_line_select_tb.sv
module spr_line_select_tb;
    import spr_scan_pkg::*;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               line_start = 1'b0;
    logic [COORD_W-1:0] line_num = '0;
    logic               bank_sel = 1'b0;
    logic [ADDR_W-1:0]  attr_addr;
    logic [ATTR_W-1:0]  attr_data;
    logic               req_valid;
    logic               req_ready = 1'b0;
    logic [IDX_W-1:0]   req_id;
    logic [COORD_W-1:0] req_x;
    logic [SIZE_W-1:0]  req_width;
    logic               scan_done;

    logic [ATTR_W-1:0] mem [0:BANKS*ENTRIES-1];
    assign attr_data = mem[attr_addr];

    always #2.5 clk = ~clk;

    spr_line_select u_dut (.*);

    int n_tests = 0;
    int n_fail  = 0;
    int exp_n;
    int exp_id [0:ENTRIES-1];
    int exp_x  [0:ENTRIES-1];
    int exp_w  [0:ENTRIES-1];

    // scenario: {pattern[2:0], line[9:0], bank, stall, flip}
    localparam logic [15:0] SCN [13] = '{
        {3'd0, 10'd10,  1'b0, 1'b0, 1'b0},
        {3'd1, 10'd10,  1'b1, 1'b1, 1'b0},
        {3'd2, 10'd20,  1'b0, 1'b1, 1'b0},
        {3'd3, 10'd5,   1'b1, 1'b0, 1'b0},
        {3'd3, 10'd5,   1'b0, 1'b0, 1'b1},
        {3'd4, 10'd3,   1'b0, 1'b1, 1'b0},
        {3'd5, 10'd0,   1'b1, 1'b0, 1'b0},
        {3'd6, 10'd99,  1'b0, 1'b0, 1'b0},
        {3'd6, 10'd100, 1'b0, 1'b1, 1'b0},
        {3'd6, 10'd107, 1'b0, 1'b0, 1'b0},
        {3'd6, 10'd108, 1'b0, 1'b0, 1'b0},
        {3'd6, 10'd163, 1'b0, 1'b0, 1'b0},
        {3'd6, 10'd164, 1'b0, 1'b0, 1'b0}
    };

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic logic [ATTR_W-1:0] gen(input int pat, input int b, input int i);
        spr_attr_t a;
        a = '0;
        case (pat)
            0: begin a.en = 1'b1; a.x = COORD_W'(i*8); a.hcode = 2'd3; end
            1: begin a.en = 1'b1; a.x = COORD_W'(i*4); a.wcode = 2'd1; a.hcode = 2'd3; end
            2: begin
                a.en = (i % 3 == 0); a.x = COORD_W'(i*5); a.y = COORD_W'((i % 4) * 16);
                a.wcode = 2'(i % 4); a.hcode = 2'(i % 3);
            end
            3: begin
                a.en = (b == 1) && (i % 2 == 1); a.x = COORD_W'(i);
                a.wcode = 2'd1; a.hcode = 2'd3;
            end
            4: begin
                a.en = (i < 10); a.x = COORD_W'(i*60); a.hcode = 2'd3;
                a.wcode = (i < 7) ? 2'd3 : (i == 7) ? 2'd2 : (i == 8) ? 2'd3 : 2'd0;
            end
            6: begin a.en = (i < 4); a.x = COORD_W'(i); a.y = 10'd100; a.hcode = 2'(i); end
            default: a = '0;
        endcase
        return ATTR_W'(a);
    endfunction

    task automatic fill(input int pat);
        for (int b = 0; b < BANKS; b++)
            for (int i = 0; i < ENTRIES; i++)
                mem[b*ENTRIES + i] = gen(pat, b, i);
    endtask

    task automatic build_exp(input int bank, input int line);
        int sum = 0;
        exp_n = 0;
        for (int i = 0; i < ENTRIES; i++) begin
            spr_attr_t a;
            int h, w;
            a = spr_attr_t'(mem[bank*ENTRIES + i]);
            h = 8 << a.hcode;
            w = 8 << a.wcode;
            if (a.en && line >= int'(a.y) && line - int'(a.y) < h) begin
                if (sum + w > BUDGET) break;
                exp_id[exp_n] = i; exp_x[exp_n] = int'(a.x); exp_w[exp_n] = w;
                exp_n++;
                sum += w;
                if (sum == BUDGET) break;
            end
        end
    endtask

    task automatic pulse_line(input int line, input bit bank, input bit flip);
        @(negedge clk);
        req_ready  = 1'b0;
        line_start = 1'b1;
        line_num   = COORD_W'(line);
        bank_sel   = bank;
        @(negedge clk);
        line_start = 1'b0;
        if (flip) bank_sel = ~bank;
    endtask

    task automatic collect(input string tag, input bit stall);
        int n = 0;
        int guard = 0;
        bit seen_done = 0;
        bit prev_stall = 0;
        int prev_id = 0;
        while (!seen_done && guard < 3000) begin
            @(negedge clk);
            guard++;
            req_ready = stall ? (guard % 3 == 0) : 1'b1;
            #1;
            if (prev_stall) chk(req_valid && int'(req_id) == prev_id, "R8", int'(req_id), prev_id);
            prev_stall = req_valid && !req_ready;
            prev_id    = int'(req_id);
            if (req_valid && req_ready) begin
                if (n < exp_n) begin
                    chk(int'(req_id) == exp_id[n], "R3", int'(req_id), exp_id[n]);
                    chk(int'(req_x) == exp_x[n], "R3", int'(req_x), exp_x[n]);
                    chk(int'(req_width) == exp_w[n], "R5", int'(req_width), exp_w[n]);
                end else begin
                    chk(1'b0, tag, n + 1, exp_n);
                end
                n++;
            end
            if (scan_done) seen_done = 1;
        end
        chk(seen_done, "R7", int'(seen_done), 1);
        chk(n == exp_n, tag, n, exp_n);
        req_ready = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1;
        chk(!req_valid, "R1", int'(req_valid), 0);
        chk(!scan_done, "R1", int'(scan_done), 0);
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk(!req_valid && !scan_done, "R1", int'(req_valid | scan_done), 0);

        foreach (SCN[k]) begin
            int pat, line;
            bit bank, stall, flip;
            string tag;
            pat   = int'(SCN[k][15:13]);
            line  = int'(SCN[k][12:3]);
            bank  = SCN[k][2];
            stall = SCN[k][1];
            flip  = SCN[k][0];
            fill(pat);
            build_exp(bank, line);
            tag = flip ? "R2" : (pat == 6) ? "R4" : (pat == 3) ? "R2" : "R6";
            pulse_line(line, bank, flip);
            collect(tag, stall);
        end

        // R7: done persists, no request while idle after the scan
        repeat (10) @(negedge clk);
        #1;
        chk(scan_done && !req_valid, "R7", int'(scan_done), 1);

        // R9: restart in the middle of a scan
        fill(0);
        build_exp(0, 10);
        pulse_line(10, 1'b0, 1'b0);
        begin
            int got = 0;
            while (got < 3) begin
                @(negedge clk);
                req_ready = 1'b1;
                #1;
                if (req_valid) got++;
            end
        end
        pulse_line(10, 1'b0, 1'b0);
        collect("R9", 1'b0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule